// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block decides when a two-rank DDR2 memory must be refreshed and when it may take commands again. A down-counter running on the controller clock credits one owed refresh to every rank each time it expires. The span it reloads is halved while a hot-case flag is high. Each rank keeps its own refresh debt, capped at a fixed bound. A command arbiter serves that debt through a per-rank request/grant handshake. Only one rank is ever requested at a time. After every accepted refresh the block holds a busy flag for the refresh recovery time, and no new request goes out while it is high.

A self-refresh request first lets every owed refresh drain. Only then does the block drop the per-rank clock-enable lines. Clock enable then stays low for at least a minimum number of cycles. When the request is withdrawn, clock enable rises again. Two separate recovery windows then start: one for ordinary commands and a longer one for reads. The arbiter watches `busy` and `readHold` to gate its own traffic. All cycle counts are parameters.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, `refReq` and `refUrgent` are 0, `ckeOut` is 2'b11, and `srActive`, `busy` and `readHold` are 0.
- R2: Counting clock edges from reset release, each rank is credited one owed refresh every REFRESH_GAP edges, the first at edge REFRESH_GAP. With no grants, `refUrgent` first reads 1 after edge 8*REFRESH_GAP.
- R3: A high `hotTemp` shortens the interval to REFRESH_GAP/2. The flag is sampled only when the counter reloads, so the interval already running keeps its length.
- R4: A rank's debt never exceeds DEBT_MAX (8). `refUrgent` is 1 exactly when some rank owes DEBT_MAX. Each accepted grant lowers that rank's debt by one, and a grant that lands on a credit edge leaves that rank's debt unchanged.
- R5: At most one bit of `refReq` is set at a time, bit index = rank. When both ranks owe, accepted grants alternate between the ranks, starting with rank 0 after reset.
- R6: After an accepted grant, `busy` is 1 for exactly RECOVER_CYCLES cycles, and `refReq` is 0 whenever `busy` is 1. With an immediate arbiter, grants are therefore RECOVER_CYCLES+1 edges apart.
- R7: While `srReq` is high and refreshes are owed, `ckeOut` stays 2'b11. The owed refreshes are requested first. Both `ckeOut` bits fall, with `srActive` rising, on the first edge where nothing is owed, `busy` is 0 and no credit arrives. After a final grant at edge G this is edge G+RECOVER_CYCLES+1.
- R8: Once lowered, `ckeOut` stays low for at least CKE_HOLD cycles, even if `srReq` is withdrawn at once.
- R9: From the edge where `ckeOut` rises, `busy` stays 1 for exactly EXIT_CMD_CYCLES cycles and `readHold` for exactly EXIT_READ_CYCLES cycles.
- R10: While `srActive` is 1, no credit accrues and `refReq` stays 0. The interval restarts at exit, so the first new credit comes REFRESH_GAP edges after `ckeOut` rises.
- R11: A `refGnt` bit presented while the matching `refReq` bit is 0 has no effect on any debt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotTemp | input | 1 | Case temperature above the normal range |
| srReq | input | 1 | Request to hold the memory in self-refresh |
| refGnt | input | 2 | Arbiter accepts the refresh of a rank (bit = rank) |
| refReq | output | 2 | Refresh wanted for a rank (bit = rank) |
| refUrgent | output | 1 | Some rank has reached the debt limit |
| ckeOut | output | 2 | Clock enable per rank |
| srActive | output | 1 | Memory held in self-refresh |
| busy | output | 1 | No command of any kind may be issued |
| readHold | output | 1 | No read may be issued |

## Verification
A refresh credit and an accepted grant can land on the same clock edge for the same rank. If that collision were mishandled, the debt would silently drift. The bench withholds grants after a credit until the next interval expires. It then presents the grant exactly on that expiry edge and lets an immediate arbiter drain the rest. It judges the result by the number of further grants: one for the served rank and two for the other, with no more before the following credit.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  localparam int RANKS = 2;

  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_SLEEP} srState_t;

  typedef struct packed {
    logic [RANKS-1:0] take;
    logic             enterSr;
    logic             exitSr;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [RANKS-1:0] owes;
    logic [RANKS-1:0] full;
    logic             tick;
    logic             ckeSettled;
  } dpStatus_t;
endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int REFRESH_GAP     = 3120,
  parameter int RECOVER_CYCLES  = 51,
  parameter int EXIT_CMD_CYCLES = 55,
  parameter int EXIT_READ_CYCLES = 200,
  parameter int CKE_HOLD        = 3,
  parameter int DEBT_MAX        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hotTemp,
  input  logic             sleepNow,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic [RANKS-1:0] ckeOut,
  output logic             busy,
  output logic             readHold
);
  localparam int GAP_W  = $clog2(REFRESH_GAP + 1);
  localparam int DEBT_W = $clog2(DEBT_MAX + 1);
  localparam int REC_W  = $clog2(RECOVER_CYCLES + 1);
  localparam int XC_W   = $clog2(EXIT_CMD_CYCLES + 1);
  localparam int XR_W   = $clog2(EXIT_READ_CYCLES + 1);
  localparam int CKE_W  = $clog2(CKE_HOLD + 1);
  localparam logic [GAP_W-1:0]  COOL_LOAD = GAP_W'(REFRESH_GAP - 1);
  localparam logic [GAP_W-1:0]  HOT_LOAD  = GAP_W'(REFRESH_GAP / 2 - 1);
  localparam logic [DEBT_W-1:0] DEBT_TOP  = DEBT_W'(DEBT_MAX);
  localparam logic [REC_W-1:0]  REC_LOAD  = REC_W'(RECOVER_CYCLES);
  localparam logic [XC_W-1:0]   XC_LOAD   = XC_W'(EXIT_CMD_CYCLES);
  localparam logic [XR_W-1:0]   XR_LOAD   = XR_W'(EXIT_READ_CYCLES);
  localparam logic [CKE_W-1:0]  CKE_LOAD  = CKE_W'(CKE_HOLD - 1);

  // interval counter
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] reloadVal;
  logic             tick;

  assign reloadVal = hotTemp ? HOT_LOAD : COOL_LOAD;
  assign tick      = (gapCnt == '0) && !sleepNow;

  always_ff @(posedge clk) begin
    if (!rstN)                 gapCnt <= COOL_LOAD;
    else if (sleepNow)         gapCnt <= reloadVal;
    else if (gapCnt == '0)     gapCnt <= reloadVal;
    else                       gapCnt <= gapCnt - 1'b1;
  end

  // per-rank refresh debt
  logic [DEBT_W-1:0] debt [RANKS];
  logic [RANKS-1:0]  owesVec;
  logic [RANKS-1:0]  fullVec;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic [DEBT_W-1:0] debtNext;

    always_comb begin
      debtNext = debt[r];
      if (tick && !strobe.take[r] && debt[r] != DEBT_TOP) debtNext = debt[r] + 1'b1;
      else if (!tick && strobe.take[r])                   debtNext = debt[r] - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) debt[r] <= '0;
      else       debt[r] <= debtNext;
    end

    assign owesVec[r] = (debt[r] != '0);
    assign fullVec[r] = (debt[r] == DEBT_TOP);

    assert_debt_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
      debt[r] <= DEBT_TOP)
      else $error("debt of rank %0d above limit", r);
  end

  // recovery timers
  logic [REC_W-1:0] recCnt;
  logic [XC_W-1:0]  xcCnt;
  logic [XR_W-1:0]  xrCnt;
  logic [CKE_W-1:0] ckeCnt;
  logic             ckeLow;

  always_ff @(posedge clk) begin
    if (!rstN)               recCnt <= '0;
    else if (|strobe.take)   recCnt <= REC_LOAD;
    else if (recCnt != '0)   recCnt <= recCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xcCnt <= '0;
      xrCnt <= '0;
    end else if (strobe.exitSr) begin
      xcCnt <= XC_LOAD;
      xrCnt <= XR_LOAD;
    end else begin
      if (xcCnt != '0) xcCnt <= xcCnt - 1'b1;
      if (xrCnt != '0) xrCnt <= xrCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeLow <= 1'b0;
      ckeCnt <= '0;
    end else if (strobe.enterSr) begin
      ckeLow <= 1'b1;
      ckeCnt <= CKE_LOAD;
    end else if (strobe.exitSr) begin
      ckeLow <= 1'b0;
      ckeCnt <= CKE_LOAD;
    end else if (ckeCnt != '0) begin
      ckeCnt <= ckeCnt - 1'b1;
    end
  end

  assign ckeOut   = {RANKS{!ckeLow}};
  assign busy     = (recCnt != '0) || (xcCnt != '0) || (ckeCnt != '0) || sleepNow;
  assign readHold = busy || (xrCnt != '0);

  always_comb begin
    status.owes       = owesVec;
    status.full       = fullVec;
    status.tick       = tick;
    status.ckeSettled = (ckeCnt == '0);
  end

  assert_drop_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut[0]) |-> $past(owesVec == '0))
    else $error("clock enable dropped with refresh owed");

  assert_cke_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ckeLow && ckeCnt != '0) |=> ckeLow)
    else $error("clock enable rose before minimum low time");

  assert_exit_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut[0]) |-> (xcCnt != '0 && xrCnt != '0 && busy && readHold))
    else $error("exit recovery windows not running");
endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srReq,
  input  logic [RANKS-1:0] refGnt,
  input  dpStatus_t        status,
  input  logic             busy,
  output ctrlStrobe_t      strobe,
  output logic             sleepNow,
  output logic [RANKS-1:0] refReq,
  output logic             refUrgent
);
  localparam int PTR_W = (RANKS > 1) ? $clog2(RANKS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RANKS - 1);

  srState_t         state, nextState;
  logic [PTR_W-1:0] ptr, sel;
  logic             found;
  logic             enterSr, exitSr;

  // round-robin pick among owing ranks
  always_comb begin
    found = 1'b0;
    sel   = ptr;
    for (int k = 0; k < RANKS; k++) begin
      if (!found && status.owes[(int'(ptr) + k) % RANKS]) begin
        found = 1'b1;
        sel   = PTR_W'((int'(ptr) + k) % RANKS);
      end
    end
  end

  always_comb begin
    refReq = '0;
    if (found && !busy) refReq[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   ptr <= '0;
    else if (|(refReq & refGnt)) ptr <= (sel == PTR_LAST) ? '0 : sel + 1'b1;
  end

  // self-refresh sequencer
  always_comb begin
    nextState = state;
    enterSr   = 1'b0;
    exitSr    = 1'b0;
    case (state)
      ST_RUN:   if (srReq) nextState = ST_DRAIN;
      ST_DRAIN: begin
        if (!srReq) nextState = ST_RUN;
        else if (status.owes == '0 && !busy && !status.tick) begin
          nextState = ST_SLEEP;
          enterSr   = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!srReq && status.ckeSettled) begin
          nextState = ST_RUN;
          exitSr    = 1'b1;
        end
      end
      default:  nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign sleepNow  = (state == ST_SLEEP);
  assign refUrgent = |status.full;

  always_comb begin
    strobe.take    = refReq & refGnt;
    strobe.enterSr = enterSr;
    strobe.exitSr  = exitSr;
  end

  assert_single_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(refReq))
    else $error("more than one rank requested");

  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (refReq == '0))
    else $error("refresh requested during recovery");

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP) |-> !status.tick)
    else $error("refresh credited during self-refresh");
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int REFRESH_GAP      = 3120,
  parameter int RECOVER_CYCLES   = 51,
  parameter int EXIT_CMD_CYCLES  = 55,
  parameter int EXIT_READ_CYCLES = 200,
  parameter int CKE_HOLD         = 3,
  parameter int DEBT_MAX         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hotTemp,
  input  logic             srReq,
  input  logic [RANKS-1:0] refGnt,
  output logic [RANKS-1:0] refReq,
  output logic             refUrgent,
  output logic [RANKS-1:0] ckeOut,
  output logic             srActive,
  output logic             busy,
  output logic             readHold
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        sleepNow;

  refsched_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srReq    (srReq),
    .refGnt   (refGnt),
    .status   (status),
    .busy     (busy),
    .strobe   (strobe),
    .sleepNow (sleepNow),
    .refReq   (refReq),
    .refUrgent(refUrgent)
  );

  refsched_dp #(
    .REFRESH_GAP     (REFRESH_GAP),
    .RECOVER_CYCLES  (RECOVER_CYCLES),
    .EXIT_CMD_CYCLES (EXIT_CMD_CYCLES),
    .EXIT_READ_CYCLES(EXIT_READ_CYCLES),
    .CKE_HOLD        (CKE_HOLD),
    .DEBT_MAX        (DEBT_MAX)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .hotTemp (hotTemp),
    .sleepNow(sleepNow),
    .strobe  (strobe),
    .status  (status),
    .ckeOut  (ckeOut),
    .busy    (busy),
    .readHold(readHold)
  );

  assign srActive = sleepNow;
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int GAP = 40, REC = 6, XCMD = 9, XRD = 20, CKEH = 3, DMAX = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, hotTemp, srReq;
  logic [1:0] refGnt, refReq, ckeOut;
  logic       refUrgent, srActive, busy, readHold;

  int  checks = 0, errors = 0, n = 0, grants = 0, gRank = 0;
  bit  spurious = 0, autoGnt = 0, gntLive = 0, gotGrant = 0;

  refresh_sched #(
    .REFRESH_GAP(GAP), .RECOVER_CYCLES(REC), .EXIT_CMD_CYCLES(XCMD),
    .EXIT_READ_CYCLES(XRD), .CKE_HOLD(CKEH), .DEBT_MAX(DMAX)
  ) u0 (
    .clk(clk), .rstN(rstN), .hotTemp(hotTemp), .srReq(srReq), .refGnt(refGnt),
    .refReq(refReq), .refUrgent(refUrgent), .ckeOut(ckeOut), .srActive(srActive),
    .busy(busy), .readHold(readHold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one clock: sample after the falling edge, then drive the grant
  task automatic cyc();
    @(negedge clk);
    n++;
    gotGrant = gntLive;
    gRank    = refGnt[1] ? 1 : 0;
    if (gotGrant) grants++;
    chk($countones(refReq) <= 1, "R5 single request", $countones(refReq), 1);
    chk(!(busy && refReq != 0), "R6 request while busy", int'(refReq), 0);
    if (spurious)     refGnt = 2'b11;
    else if (autoGnt) refGnt = refReq;
    else              refGnt = 2'b00;
    gntLive = !spurious && autoGnt && (refReq != 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired at edge %0d", n);
    finish_run();
  end

  initial begin
    int firstN, gi, busyCnt, lastG, phase, eEdge, firstReq, low;
    int gN [6];
    int gR [6];
    rstN = 1'b0; hotTemp = 1'b0; srReq = 1'b0; refGnt = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(refReq == 0 && !refUrgent, "R1 request idle", int'(refReq), 0);
    chk(ckeOut == 2'b11, "R1 clock enable high", int'(ckeOut), 3);
    chk(!srActive && !busy && !readHold, "R1 flags low", int'({srActive, busy, readHold}), 0);

    // R11 stray grants before any credit, then R2 interval
    rstN = 1'b1; spurious = 1'b1; refGnt = 2'b11;
    while (n < GAP - 2) cyc();
    spurious = 1'b0;
    cyc();
    cyc();
    chk(n == GAP && refReq == 2'b01, "R5 rank 0 first", int'(refReq), 1);
    chk(!refUrgent, "R2 not urgent after one credit", int'(refUrgent), 0);
    firstN = -1;
    while (firstN < 0 && n < 10 * GAP) begin
      cyc();
      if (refUrgent) firstN = n;
    end
    chk(firstN == 8 * GAP, "R2 R11 urgent after eight intervals", firstN, 8 * GAP);

    // R4 R5 R6 drain with an immediate arbiter
    autoGnt = 1'b1;
    gi = 0; busyCnt = 0;
    while (gi < 6 && n < 700) begin
      cyc();
      if (gotGrant) begin
        gN[gi] = n; gR[gi] = gRank; gi++;
        if (gi == 1) chk(refUrgent, "R4 urgent while other rank full", 0, 1);
        if (gi == 2) chk(!refUrgent, "R4 urgent clears when both below limit", 1, 0);
      end
      if (gi == 1 && busy) busyCnt++;
    end
    chk(busyCnt == REC, "R6 busy length after grant", busyCnt, REC);
    for (int k = 0; k < 6; k++)
      chk(gR[k] == (k % 2), "R5 grants alternate", gR[k], k % 2);
    for (int k = 1; k < 6; k++)
      chk(gN[k] - gN[k-1] == REC + 1, "R6 grant spacing", gN[k] - gN[k-1], REC + 1);

    // R4 credit and grant on the same edge
    while (n < 15 * GAP - 2) cyc();
    autoGnt = 1'b0;
    cyc();
    chk(refReq == 0 && !busy, "R4 debt drained", int'(refReq), 0);
    cyc();
    chk(refReq != 0, "R2 credit on interval edge", int'(refReq), 1);
    while (n < 16 * GAP - 2) cyc();
    autoGnt = 1'b1;
    cyc();
    grants = 0;
    while (n < 16 * GAP + 35) cyc();
    chk(grants == 4, "R4 coincident credit and grant", grants, 4);

    // R3 hot interval takes effect at the next reload
    autoGnt = 1'b0; hotTemp = 1'b1;
    firstN = -1;
    while (firstN < 0 && n < 30 * GAP) begin
      cyc();
      if (refUrgent) firstN = n;
    end
    chk(firstN == 17 * GAP + 7 * (GAP / 2), "R3 halved interval", firstN, 17 * GAP + 7 * (GAP / 2));

    // R7 self-refresh entry waits for owed refreshes
    hotTemp = 1'b0; autoGnt = 1'b1;
    while (n < 26 * GAP - 1) cyc();
    autoGnt = 1'b0;
    chk(refReq == 0 && !busy, "R4 debt drained before sleep", int'(refReq), 0);
    cyc();
    chk(refReq != 0, "R7 refresh owed", int'(refReq), 1);
    srReq = 1'b1;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk(ckeOut == 2'b11 && !srActive, "R7 no entry while owed", int'(ckeOut), 3);
    end
    autoGnt = 1'b1; phase = grants; lastG = 0;
    while (ckeOut == 2'b11 && n < 28 * GAP) begin
      cyc();
      if (gotGrant) lastG = n;
    end
    chk(grants - phase == 2, "R7 owed refreshes served first", grants - phase, 2);
    chk(n == lastG + REC + 1, "R7 entry edge", n - lastG, REC + 1);
    chk(ckeOut == 2'b00 && srActive, "R7 both ranks low", int'(ckeOut), 0);

    // R10 no credit while sleeping
    for (int k = 0; k < 60; k++) begin
      cyc();
      chk(refReq == 0 && ckeOut == 2'b00 && srActive, "R10 quiet in self-refresh", int'(refReq), 0);
    end

    // R9 exit recovery windows
    srReq = 1'b0;
    cyc();
    eEdge = n;
    chk(ckeOut == 2'b11 && !srActive, "R9 clock enable restored", int'(ckeOut), 3);
    firstReq = -1;
    while (n < eEdge + GAP + 20) begin
      if (n == eEdge + XCMD - 1) chk(busy, "R9 busy last cycle", 0, 1);
      if (n == eEdge + XCMD)     chk(!busy, "R9 busy released", 1, 0);
      if (n == eEdge + XRD - 1)  chk(readHold, "R9 read hold last cycle", 0, 1);
      if (n == eEdge + XRD)      chk(!readHold, "R9 read hold released", 1, 0);
      if (firstReq < 0 && refReq != 0) firstReq = n;
      cyc();
    end
    chk(firstReq == eEdge + GAP, "R10 interval restarts at exit", firstReq - eEdge, GAP);

    // R8 minimum clock-enable low time
    srReq = 1'b1;
    for (int k = 0; k < 10 && ckeOut == 2'b11; k++) cyc();
    srReq = 1'b0;
    low = 0;
    for (int k = 0; k < 20 && ckeOut == 2'b00; k++) begin
      low++;
      cyc();
    end
    chk(low == CKEH, "R8 clock enable low time", low, CKEH);
    repeat (3) cyc();
    finish_run();
  end
endmodule